// File: doc/BRIEF.md
# Paced Register-Write Command FIFO

This block sits between a host register-write port and a drawing engine. Each host write carries an address and a data word. In buffered mode the write is stored and later forwarded to the engine in arrival order, one entry per cycle while the engine signals ready. In direct mode the write goes straight to the engine in the same cycle. A control word selects the mode, and a switch to direct mode waits until the buffer has emptied.

Software paces its writes with a free-slot count. The storage is counted in slots, and each buffered write takes two of them. A write that finds no room is dropped and sets a sticky overrun flag. A busy status stays high while anything is pending or the engine reports an active operation.

Writes that land in the drawing-command window are decoded as the entry reaches the engine. Modifier bits in the address request a rectangle fill or a rectangle copy, and a one-cycle start pulse goes out with the transfer.

Top module: `regwr_cmd_fifo`

## Requirements
- R1: After reset, `free_slots` equals SLOTS (2048), `status_busy` is 0, `overrun` is 0 and `eng_valid` is 0.
- R2: Each accepted buffered write lowers `free_slots` by 2 and each entry forwarded from the buffer raises it by 2. When a write is accepted and an entry is forwarded in the same cycle, `free_slots` does not change.
- R3: At most SLOTS/2 (1024) writes can be pending, and `free_slots` then reads 0. A buffered write that arrives while fewer than two slots are free is dropped and sets `overrun`, which stays at 1 until reset.
- R4: While `eng_ready` is 1, buffered entries appear on `eng_addr`/`eng_data` with `eng_valid` high, one per cycle and strictly in arrival order. An entry is held while `eng_ready` is 0.
- R5: `status_busy` is 1 when any entry is pending or `eng_busy` is 1, and 0 otherwise.
- R6: A forwarded write whose address has bits 23:12 equal to 0xB3C, bit 11 set and bit 10 clear pulses `eng_start_fill` in its transfer cycle. Bits 9 and 8 do not affect this.
- R7: A forwarded write in that window with bits 11 and 10 both set pulses `eng_start_copy` in its transfer cycle. Bits 9 and 8 do not affect this.
- R8: A write with bit 11 clear, or with an address outside the window, pulses neither start output. A start pulse lasts only for the single transfer cycle.
- R9: When `ctrl_word` bit 9 is 1 and the buffer is empty, the mode is direct. A host write then appears on the engine outputs in the same cycle and `free_slots` stays at SLOTS. A direct write made while `eng_ready` is 0 is dropped and sets `overrun`.
- R10: If bit 9 is set while entries are pending, buffered operation continues, and new writes are still buffered, until the buffer has emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word; bit 9 requests direct mode |
| host_wr_valid | input | 1 | Host write strobe |
| host_wr_addr | input | 24 | Host write address |
| host_wr_data | input | 32 | Host write data |
| eng_ready | input | 1 | Engine can take an entry this cycle |
| eng_busy | input | 1 | Engine has an operation in progress |
| eng_valid | output | 1 | Entry presented to the engine |
| eng_addr | output | 24 | Presented address |
| eng_data | output | 32 | Presented data |
| eng_start_fill | output | 1 | One-cycle rectangle-fill launch |
| eng_start_copy | output | 1 | One-cycle rectangle-copy launch |
| free_slots | output | 12 | Free slot count, two per pending write |
| status_busy | output | 1 | Nonzero while pending entries or engine active |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
Two functions can fall in the same cycle. The first pair is a new write being stored while the head entry is forwarded, which the bench provokes by streaming one write per cycle with the engine ready. It judges this by `free_slots` holding at 2046 while each cycle's output carries the write from the cycle before. The second pair is the final drain of the buffer while a direct-mode request is pending. Here the bench checks that the last buffered entries come out in order first, and that the next host write then appears on the engine outputs in the same cycle.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_entry_t;

  typedef enum logic [1:0] {
    LNCH_NONE = 2'd0,
    LNCH_FILL = 2'd1,
    LNCH_COPY = 2'd2
  } launch_t;
endpackage

// File: rtl/regwr_launch_decode.sv
module regwr_launch_decode
  import regwr_pkg::*;
#(
  parameter int               WIN_LSB  = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hB3C000,
  parameter bit               USE_WIN  = 1'b1,
  parameter int               GO_BIT   = 11,
  parameter int               SEL_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output launch_t           kind
);
  logic in_win;

  generate
    if (USE_WIN) begin : g_win
      assign in_win = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    end else begin : g_nowin
      assign in_win = 1'b1;
    end
  endgenerate

  always_comb begin
    kind = LNCH_NONE;
    if (in_win && addr[GO_BIT]) begin
      kind = addr[SEL_BIT] ? LNCH_COPY : LNCH_FILL;
    end
  end

  // R7: a copy is only ever decoded from an address with the select bit set
  p_copy_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LNCH_COPY) |-> addr[SEL_BIT]);
  // R8: no launch without the go bit
  p_no_go_no_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[GO_BIT] |-> (kind == LNCH_NONE));
endmodule

// File: rtl/regwr_slot_store.sv
module regwr_slot_store
  import regwr_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  wr_entry_t        push_entry,
  input  logic             pop,
  output wr_entry_t        head_entry,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             nxt_empty
);
  wr_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_entry;
  end

  assign head_entry = mem[rd_ptr_q];
  assign count      = cnt_q;
  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign nxt_empty  = (cnt_d == '0);

  // R3: pending entries never exceed the storage depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R4: nothing is removed from an empty store
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/regwr_mode_ctl.sv
module regwr_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic direct_req,
  input  logic nxt_empty,
  output logic direct_q
);
  logic mode_q, mode_d, mode_en;

  assign mode_en = nxt_empty;

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = direct_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign direct_q = mode_q;
endmodule

// File: rtl/regwr_cmd_fifo.sv
module regwr_cmd_fifo
  import regwr_pkg::*;
#(
  parameter int SLOTS      = 2048,
  parameter int SLOTS_PER  = 2,
  parameter int DIRECT_BIT = 9,
  localparam int DEPTH  = SLOTS / SLOTS_PER,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FREE_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic              host_wr_valid,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              eng_ready,
  input  logic              eng_busy,
  output logic              eng_valid,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_data,
  output logic              eng_start_fill,
  output logic              eng_start_copy,
  output logic [FREE_W-1:0] free_slots,
  output logic              status_busy,
  output logic              overrun
);
  wr_entry_t        host_entry, head_entry, out_entry;
  logic [CNT_W-1:0] count;
  logic             empty, full, nxt_empty;
  logic             direct_q;
  logic             fifo_req, push, pop, xfer, drop;
  logic             ovr_q, ovr_d;
  launch_t          kind;

  assign host_entry = '{addr: host_wr_addr, data: host_wr_data};

  assign fifo_req = host_wr_valid && !direct_q;
  assign push     = fifo_req && !full;
  assign pop      = !direct_q && !empty && eng_ready;
  assign drop     = (fifo_req && full) || (host_wr_valid && direct_q && !eng_ready);

  regwr_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_entry (host_entry),
    .pop        (pop),
    .head_entry (head_entry),
    .count      (count),
    .empty      (empty),
    .full       (full),
    .nxt_empty  (nxt_empty)
  );

  regwr_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .direct_req (ctrl_word[DIRECT_BIT]),
    .nxt_empty  (nxt_empty),
    .direct_q   (direct_q)
  );

  assign out_entry = direct_q ? host_entry : head_entry;
  assign eng_valid = direct_q ? host_wr_valid : !empty;
  assign eng_addr  = out_entry.addr;
  assign eng_data  = out_entry.data;
  assign xfer      = eng_valid && eng_ready;

  regwr_launch_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (out_entry.addr),
    .kind  (kind)
  );

  assign eng_start_fill = xfer && (kind == LNCH_FILL);
  assign eng_start_copy = xfer && (kind == LNCH_COPY);

  always_comb begin
    ovr_d = ovr_q;
    if (drop) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun     = ovr_q;
  assign free_slots  = FREE_W'(SLOTS) - FREE_W'(count * SLOTS_PER);
  assign status_busy = !empty || eng_busy;

  // R3: overrun is sticky
  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R3: a full store reports no free slots
  p_full_free_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (free_slots == '0));
  // R5: pending work keeps the status busy
  p_busy_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots != FREE_W'(SLOTS)) |-> status_busy);
  // R10: entering direct mode only happens with an empty store
  p_defer_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(direct_q) |-> empty);
  // R8: a start pulse coincides with an engine handshake
  p_pulse_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start_fill || eng_start_copy) |-> (eng_ready && eng_valid));
endmodule

// File: tb/regwr_cmd_fifo_tb_top.sv
module regwr_cmd_fifo_tb_top;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 2048;
  localparam int DEPTH  = SLOTS / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic        host_wr_valid;
  logic [23:0] host_wr_addr;
  logic [31:0] host_wr_data;
  logic        eng_ready, eng_busy;
  logic        eng_valid, eng_start_fill, eng_start_copy;
  logic [23:0] eng_addr;
  logic [31:0] eng_data;
  logic [11:0] free_slots;
  logic        status_busy, overrun;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(PERIOD/2) clk = ~clk;

  regwr_cmd_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .eng_ready(eng_ready), .eng_busy(eng_busy),
    .eng_valid(eng_valid), .eng_addr(eng_addr), .eng_data(eng_data),
    .eng_start_fill(eng_start_fill), .eng_start_copy(eng_start_copy),
    .free_slots(free_slots), .status_busy(status_busy), .overrun(overrun)
  );

  // address, expect fill, expect copy
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {24'hB3C808, 1'b1, 1'b0},
    {24'hB3C908, 1'b1, 1'b0},
    {24'hB3CA08, 1'b1, 1'b0},
    {24'hB3CC00, 1'b0, 1'b1},
    {24'hB3CD10, 1'b0, 1'b1},
    {24'hB3CE00, 1'b0, 1'b1},
    {24'hB3C400, 1'b0, 1'b0},
    {24'hB3C100, 1'b0, 1'b0},
    {24'hB3C010, 1'b0, 1'b0},
    {24'h641C00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_valid = 1'b1;
    host_wr_addr  = a;
    host_wr_data  = d;
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #(PERIOD*2);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    ctrl_word = '0; host_wr_valid = 0; host_wr_addr = '0; host_wr_data = '0;
    eng_ready = 0; eng_busy = 0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 free", 32'(free_slots), SLOTS);
    check("R1 busy", 32'(status_busy), 0);
    check("R1 overrun", 32'(overrun), 0);
    check("R1 valid", 32'(eng_valid), 0);

    // R6 R7 R8 launch decode table
    eng_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][25:2], 32'h100 + i);
      check("R4 vec valid", 32'(eng_valid), 1);
      check("R4 vec addr", 32'(eng_addr), 32'(VEC[i][25:2]));
      check("R6 fill pulse", 32'(eng_start_fill), 32'(VEC[i][1]));
      check("R7 copy pulse", 32'(eng_start_copy), 32'(VEC[i][0]));
      @(negedge clk);
      check("R8 pulse one cycle", 32'({eng_start_fill, eng_start_copy}), 0);
    end

    // R2 R4 hold and order
    eng_ready = 1'b0;
    for (int i = 0; i < 3; i++) wr(24'h000010 + 24'(i*4), 32'hC0DE_0000 + i);
    check("R2 free after 3", 32'(free_slots), SLOTS - 6);
    check("R5 busy pending", 32'(status_busy), 1);
    check("R4 held", 32'(eng_data), 32'hC0DE_0000);
    check("R8 no pulse unready", 32'({eng_start_fill, eng_start_copy}), 0);
    eng_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R4 order", eng_data, 32'hC0DE_0000 + i);
      @(negedge clk);
    end
    check("R2 free drained", 32'(free_slots), SLOTS);
    check("R5 idle", 32'(status_busy), 0);
    eng_busy = 1'b1; #1;
    check("R5 engine busy", 32'(status_busy), 1);
    eng_busy = 1'b0;

    // R2 streaming push and pop in the same cycle
    @(negedge clk);
    host_wr_valid = 1'b1; host_wr_addr = 24'h20; host_wr_data = 32'h5000;
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      check("R2 stream free", 32'(free_slots), SLOTS - 2);
      check("R4 stream data", eng_data, 32'h5000 + k - 1);
      host_wr_data = 32'h5000 + k;
    end
    host_wr_valid = 1'b0;
    @(negedge clk);
    check("R2 stream end", 32'(free_slots), SLOTS);

    // R3 capacity and overrun
    eng_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) wr(24'h30, 32'h7000 + i);
    check("R3 free zero", 32'(free_slots), 0);
    check("R3 no overrun yet", 32'(overrun), 0);
    wr(24'h30, 32'hDEAD);
    check("R3 overrun set", 32'(overrun), 1);
    check("R3 free stays zero", 32'(free_slots), 0);
    eng_ready = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        if (eng_data !== 32'h7000 + i || eng_valid !== 1'b1) bad++;
        @(negedge clk);
      end
      check("R4 full drain order", bad, 0);
    end
    check("R3 dropped write absent", 32'(eng_valid), 0);
    check("R3 overrun sticky", 32'(overrun), 1);
    do_reset();
    @(negedge clk);
    check("R3 overrun cleared by reset", 32'(overrun), 0);

    // R10 deferred switch
    eng_ready = 1'b0;
    wr(24'h40, 32'h9000);
    wr(24'h44, 32'h9001);
    ctrl_word = 32'h0000_0200;
    wr(24'h48, 32'h9002);
    check("R10 still buffered", 32'(free_slots), SLOTS - 6);
    check("R10 head from store", eng_data, 32'h9000);
    eng_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R10 drain order", eng_data, 32'h9000 + i);
      @(negedge clk);
    end

    // R9 direct mode
    host_wr_valid = 1'b1; host_wr_addr = 24'hB3C808; host_wr_data = 32'hAAAA;
    #1;
    check("R9 direct valid", 32'(eng_valid), 1);
    check("R9 direct data", eng_data, 32'hAAAA);
    check("R9 direct fill", 32'(eng_start_fill), 1);
    check("R9 free full", 32'(free_slots), SLOTS);
    @(negedge clk);
    host_wr_valid = 1'b0;
    check("R9 no overrun", 32'(overrun), 0);
    eng_ready = 1'b0;
    wr(24'h50, 32'hBBBB);
    check("R9 direct drop overrun", 32'(overrun), 1);
    check("R9 direct free", 32'(free_slots), SLOTS);

    finish_run();
  end
endmodule